// File: doc/BRIEF.md
# Spare-Area Syndrome Code Byte Codec

This block sits between a four-error syndrome engine and the flash data path. It converts between the engine's eight 10-bit check values and the ten bytes those values take in the page's spare area. On the write side, it takes the engine's raw 32-bit result words. It accepts one pair of words, streams out five packed bytes, and then accepts the next pair. After two pairs it has produced all ten bytes, and the last byte is marked.

On the read side, the ten stored bytes stream in one per handshake. One cycle after the tenth byte, a one-cycle done pulse appears. The erased flag is raised with that pulse when every byte was 0xFF; such a page needs no correction and nothing further is produced. In every other case, the block rebuilds the eight 10-bit values. It then presents them on a load port, highest value index first, so the engine can preload its expected codes.

Every port uses valid/ready handshakes. A synchronous active-high reset returns both paths to their idle state.

Top module: `ecc_spare_codec`

## Requirements
- R1: After reset, `wr_word_ready` and `rd_byte_ready` are 1, while `wr_byte_valid`, `wr_byte_last`, `ld_valid`, `rd_done` and `rd_erased` are 0.
- R2: A raw word contributes only bits 9:0 (the lower value of the word) and bits 25:16 (the upper value); the state of every other bit has no effect on the bytes produced.
- R3: The words in arrival order hold values 0..7: word n gives value 2n from bits 9:0 and value 2n+1 from bits 25:16. Value k fills bits 10k..10k+9 of an 80-bit stream, and byte j sent is stream bits 8j+7..8j. Bytes go out lowest j first, five after each pair of words.
- R4: `wr_word_ready` is 0 while packed bytes are pending, and a byte offered but not taken stays unchanged on `wr_byte`.
- R5: `wr_byte_last` is 1 on the tenth byte of a frame and 0 on the other nine.
- R6: Read bytes fill the 80-bit stream lowest byte first. `rd_done` pulses for one cycle in the cycle after the tenth byte is accepted, and never after fewer bytes.
- R7: `rd_erased` is 1 with `rd_done` exactly when all ten bytes were 0xFF. Such a frame produces no load, and `rd_byte_ready` is 1 again at once.
- R8: For any other frame, the eight values rebuilt under the R3 layout go out on `ld_code` with `ld_index` running 7, 6, ..., 0, one per load handshake.
- R9: While loads are pending, `rd_byte_ready` is 0, and an unaccepted load keeps `ld_code` and `ld_index` steady.
- R10: A frame with a single byte other than 0xFF is not erased. The all-ones tracker rearms at every frame boundary, so an all-0xFF frame after a non-erased frame is again reported erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_word | input | 32 | Raw engine result word |
| wr_word_valid | input | 1 | Raw word offered |
| wr_word_ready | output | 1 | Raw word can be taken |
| wr_byte | output | 8 | Packed spare-area byte |
| wr_byte_valid | output | 1 | Packed byte offered |
| wr_byte_ready | input | 1 | Packed byte taken |
| wr_byte_last | output | 1 | Tenth byte of the frame |
| rd_byte | input | 8 | Stored spare-area byte |
| rd_byte_valid | input | 1 | Stored byte offered |
| rd_byte_ready | output | 1 | Stored byte can be taken |
| ld_code | output | 10 | Rebuilt 10-bit value for the engine |
| ld_index | output | 3 | Index of the value on `ld_code` |
| ld_valid | output | 1 | Load value offered |
| ld_ready | input | 1 | Load value taken |
| rd_done | output | 1 | One-cycle pulse after the tenth stored byte |
| rd_erased | output | 1 | Frame was all 0xFF, valid with `rd_done` |

## Verification
A slip in the write-side byte or pair counter shows up within the first frame. It appears as a byte taken from the wrong bit offset, or as `wr_byte_last` on the wrong byte, and it corrupts every later frame too. A read-side counter error moves the `rd_done` pulse off the cycle after the tenth byte. A tracker that fails to rearm is seen only on the next frame: an all-0xFF frame that follows a normal one is then not flagged erased. A wrong load index sequence or stream position shows up in the first value loaded, so the bench compares every loaded value and index with codes it unpacks on its own.

// File: rtl/ecc_codec_pkg.sv
package ecc_codec_pkg;
  localparam int CODE_W    = 10;
  localparam int NUM_CODES = 8;
  localparam int WORD_W    = 32;
  localparam int HALF_OFS  = 16;
  localparam int BYTE_W    = 8;
  localparam int STREAM_W  = CODE_W * NUM_CODES;
  localparam int NUM_BYTES = STREAM_W / BYTE_W;
  localparam int IDX_W     = $clog2(NUM_CODES);

  // Two code values held in one raw word, lower half first.
  function automatic logic [2*CODE_W-1:0] word_fields(input logic [WORD_W-1:0] w);
    return {w[HALF_OFS +: CODE_W], w[0 +: CODE_W]};
  endfunction

  // Code value k out of the little-endian packed stream.
  function automatic logic [CODE_W-1:0] pick_code(input logic [STREAM_W-1:0] s,
                                                  input logic [IDX_W-1:0] k);
    return s[int'(k)*CODE_W +: CODE_W];
  endfunction
endpackage

// File: rtl/erase_detect.sv
module erase_detect
  import ecc_codec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_fire,
  input  logic              frame_end,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              all_ones
);
  logic tracked_q;

  assign all_ones = tracked_q & (byte_i == {BYTE_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      tracked_q <= 1'b1;
    end else if (byte_fire) begin
      tracked_q <= frame_end ? 1'b1 : all_ones;
    end
  end
endmodule

// File: rtl/ecc_pack_tx.sv
module ecc_pack_tx
  import ecc_codec_pkg::*;
#(
  parameter int WORDS_PER_GROUP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid,
  output logic              word_ready,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic              byte_last
);
  localparam int GROUP_BITS  = WORDS_PER_GROUP * 2 * CODE_W;
  localparam int GROUP_BYTES = GROUP_BITS / BYTE_W;
  localparam int NUM_GROUPS  = NUM_CODES / (2 * WORDS_PER_GROUP);
  localparam int WI_W        = (WORDS_PER_GROUP > 1) ? $clog2(WORDS_PER_GROUP) : 1;
  localparam int BI_W        = $clog2(GROUP_BYTES);
  localparam int GI_W        = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic                  sending_q;
  logic [WI_W-1:0]       word_idx_q;
  logic [BI_W-1:0]       byte_idx_q;
  logic [GI_W-1:0]       group_idx_q;
  logic [GROUP_BITS-1:0] group_q;
  logic                  word_fire;
  logic                  byte_fire;
  logic                  group_end;

  assign word_ready = !sending_q;
  assign byte_valid = sending_q;
  assign byte_o     = group_q[BYTE_W-1:0];
  assign word_fire  = word_valid && word_ready;
  assign byte_fire  = byte_valid && byte_ready;
  assign group_end  = byte_idx_q == BI_W'(GROUP_BYTES - 1);
  assign byte_last  = sending_q && group_end && (group_idx_q == GI_W'(NUM_GROUPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sending_q   <= 1'b0;
      word_idx_q  <= '0;
      byte_idx_q  <= '0;
      group_idx_q <= '0;
      group_q     <= '0;
    end else begin
      if (word_fire) begin
        group_q[int'(word_idx_q)*2*CODE_W +: 2*CODE_W] <= word_fields(word_i);
        if (word_idx_q == WI_W'(WORDS_PER_GROUP - 1)) begin
          word_idx_q <= '0;
          sending_q  <= 1'b1;
        end else begin
          word_idx_q <= word_idx_q + 1'b1;
        end
      end
      if (byte_fire) begin
        group_q <= group_q >> BYTE_W;
        if (group_end) begin
          byte_idx_q <= '0;
          sending_q  <= 1'b0;
          group_idx_q <= (group_idx_q == GI_W'(NUM_GROUPS - 1)) ? '0 : group_idx_q + 1'b1;
        end else begin
          byte_idx_q <= byte_idx_q + 1'b1;
        end
      end
    end
  end

  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_o)) else $error("byte hold"); // R4
  AST_NO_WORD_WHILE_SEND: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> !word_ready) else $error("word while send"); // R4
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    byte_last |-> byte_valid) else $error("last without valid"); // R5
  AST_LAST_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    byte_last && byte_ready |=> !byte_valid && word_ready) else $error("last not final"); // R5
endmodule

// File: rtl/ecc_unpack_rx.sv
module ecc_unpack_rx
  import ecc_codec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid,
  output logic              byte_ready,
  output logic [CODE_W-1:0] ld_code,
  output logic [IDX_W-1:0]  ld_index,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic              frame_done,
  output logic              frame_erased
);
  localparam int CNT_W = $clog2(NUM_BYTES);

  logic                emitting_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [STREAM_W-1:0] stream_q;
  logic [IDX_W-1:0]    idx_q;
  logic                done_q;
  logic                erased_q;
  logic                byte_fire;
  logic                ld_fire;
  logic                frame_end;
  logic                erased_now;

  assign byte_ready   = !emitting_q;
  assign byte_fire    = byte_valid && byte_ready;
  assign ld_valid     = emitting_q;
  assign ld_fire      = ld_valid && ld_ready;
  assign ld_index     = idx_q;
  assign ld_code      = pick_code(stream_q, idx_q);
  assign frame_end    = cnt_q == CNT_W'(NUM_BYTES - 1);
  assign frame_done   = done_q;
  assign frame_erased = done_q && erased_q;

  erase_detect u_det (
    .clk       (clk),
    .rst       (rst),
    .byte_fire (byte_fire),
    .frame_end (frame_end),
    .byte_i    (byte_i),
    .all_ones  (erased_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      emitting_q <= 1'b0;
      cnt_q      <= '0;
      stream_q   <= '0;
      idx_q      <= '0;
      done_q     <= 1'b0;
      erased_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (byte_fire) begin
        stream_q <= {byte_i, stream_q[STREAM_W-1:BYTE_W]};
        if (frame_end) begin
          cnt_q    <= '0;
          done_q   <= 1'b1;
          erased_q <= erased_now;
          if (!erased_now) begin
            emitting_q <= 1'b1;
            idx_q      <= IDX_W'(NUM_CODES - 1);
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (ld_fire) begin
        if (idx_q == '0) emitting_q <= 1'b0;
        else             idx_q      <= idx_q - 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done) else $error("done not a pulse"); // R6
  AST_ERASED_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    frame_erased |-> !ld_valid && byte_ready) else $error("erased frame loads"); // R7
  AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (rst)
    $rose(ld_valid) |-> ld_index == IDX_W'(NUM_CODES - 1)) else $error("first index"); // R8
  AST_DESCEND: assert property (@(posedge clk) disable iff (rst)
    ld_fire && ld_index != '0 |=> ld_valid && ld_index == $past(ld_index) - 1'b1) else $error("index order"); // R8
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    ld_valid && !ld_ready |=> ld_valid && $stable(ld_code) && $stable(ld_index)) else $error("load hold"); // R9
  AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> !byte_ready) else $error("rx not blocked"); // R9
endmodule

// File: rtl/ecc_spare_codec.sv
module ecc_spare_codec
  import ecc_codec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] wr_word,
  input  logic        wr_word_valid,
  output logic        wr_word_ready,
  output logic [7:0]  wr_byte,
  output logic        wr_byte_valid,
  input  logic        wr_byte_ready,
  output logic        wr_byte_last,
  input  logic [7:0]  rd_byte,
  input  logic        rd_byte_valid,
  output logic        rd_byte_ready,
  output logic [9:0]  ld_code,
  output logic [2:0]  ld_index,
  output logic        ld_valid,
  input  logic        ld_ready,
  output logic        rd_done,
  output logic        rd_erased
);
  ecc_pack_tx #(.WORDS_PER_GROUP(2)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .word_i     (wr_word),
    .word_valid (wr_word_valid),
    .word_ready (wr_word_ready),
    .byte_o     (wr_byte),
    .byte_valid (wr_byte_valid),
    .byte_ready (wr_byte_ready),
    .byte_last  (wr_byte_last)
  );

  ecc_unpack_rx u_rx (
    .clk          (clk),
    .rst          (rst),
    .byte_i       (rd_byte),
    .byte_valid   (rd_byte_valid),
    .byte_ready   (rd_byte_ready),
    .ld_code      (ld_code),
    .ld_index     (ld_index),
    .ld_valid     (ld_valid),
    .ld_ready     (ld_ready),
    .frame_done   (rd_done),
    .frame_erased (rd_erased)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> wr_word_ready && rd_byte_ready && !wr_byte_valid && !ld_valid) else $error("reset idle"); // R1
endmodule

// File: tb/ecc_spare_codec_bench.sv
`timescale 1ns/1ps
module ecc_spare_codec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] wr_word = '0;
  logic        wr_word_valid = 1'b0;
  logic        wr_word_ready;
  logic [7:0]  wr_byte;
  logic        wr_byte_valid;
  logic        wr_byte_ready = 1'b0;
  logic        wr_byte_last;
  logic [7:0]  rd_byte = '0;
  logic        rd_byte_valid = 1'b0;
  logic        rd_byte_ready;
  logic [9:0]  ld_code;
  logic [2:0]  ld_index;
  logic        ld_valid;
  logic        ld_ready = 1'b0;
  logic        rd_done;
  logic        rd_erased;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ecc_spare_codec u_ecc_spare_codec (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [9:0] lo, input logic [9:0] hi, input logic [5:0] junk);
    return {junk, hi, junk, lo};
  endfunction

  // Bench model of the stream: built bit by bit from the word halves.
  function automatic logic [79:0] model_stream(input logic [127:0] ws);
    logic [79:0] s = '0;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] w = ws[32*(k/2) +: 32];
      for (int b = 0; b < 10; b++) s[10*k + b] = w[(k % 2 == 1 ? 16 : 0) + b];
    end
    return s;
  endfunction

  function automatic logic [9:0] model_code(input logic [79:0] s, input int k);
    logic [9:0] c;
    for (int b = 0; b < 10; b++) c[b] = s[10*k + b];
    return c;
  endfunction

  task automatic push_word(input logic [31:0] w);
    wr_word = w; wr_word_valid = 1'b1;
    while (!wr_word_ready) @(negedge clk);
    @(negedge clk);
    wr_word_valid = 1'b0;
  endtask

  task automatic pull_byte(input bit stall, output logic [7:0] b, output logic last);
    while (!wr_byte_valid) @(negedge clk);
    if (stall) begin
      logic [7:0] first = wr_byte;
      chk(!wr_word_ready, "R4 word ready during send", {31'b0, wr_word_ready}, 32'd0);
      repeat (2) @(negedge clk);
      chk(wr_byte_valid && wr_byte == first, "R4 byte held", {24'b0, wr_byte}, {24'b0, first});
    end
    b = wr_byte; last = wr_byte_last;
    wr_byte_ready = 1'b1;
    @(negedge clk);
    wr_byte_ready = 1'b0;
  endtask

  task automatic t_pack(input logic [127:0] ws, input bit stall, input string req, output logic [79:0] got);
    logic [79:0] exp = model_stream(ws);
    for (int g = 0; g < 2; g++) begin
      push_word(ws[64*g +: 32]);
      push_word(ws[64*g + 32 +: 32]);
      for (int j = 0; j < 5; j++) begin
        logic [7:0] b; logic last;
        int n = 5*g + j;
        pull_byte(stall && j == 2, b, last);
        got[8*n +: 8] = b;
        chk(b == exp[8*n +: 8], req, {24'b0, b}, {24'b0, exp[8*n +: 8]});
        chk(last == (n == 9), "R5 last marker", {31'b0, last}, {31'b0, n == 9});
      end
    end
  endtask

  task automatic push_rd(input logic [7:0] b);
    rd_byte = b; rd_byte_valid = 1'b1;
    while (!rd_byte_ready) @(negedge clk);
    @(negedge clk);
    rd_byte_valid = 1'b0;
  endtask

  task automatic t_unpack(input logic [79:0] s, input bit exp_erased, input bit stall, input string req);
    for (int i = 0; i < 10; i++) begin
      push_rd(s[8*i +: 8]);
      if (i == 8) chk(!rd_done, "R6 no early done", {31'b0, rd_done}, 32'd0);
    end
    chk(rd_done, "R6 done after tenth byte", {31'b0, rd_done}, 32'd1);
    chk(rd_erased == exp_erased, req, {31'b0, rd_erased}, {31'b0, exp_erased});
    if (exp_erased) begin
      chk(!ld_valid && rd_byte_ready, "R7 erased skips loads", {30'b0, ld_valid, rd_byte_ready}, 32'd1);
      @(negedge clk);
      chk(!ld_valid && !rd_done, "R7 quiet after erased", {30'b0, ld_valid, rd_done}, 32'd0);
    end else begin
      for (int i = 7; i >= 0; i--) begin
        while (!ld_valid) @(negedge clk);
        chk(!rd_byte_ready, "R9 input blocked", {31'b0, rd_byte_ready}, 32'd0);
        if (stall && i == 4) begin
          logic [9:0] c0 = ld_code;
          repeat (2) @(negedge clk);
          chk(ld_valid && ld_code == c0 && ld_index == 3'(i), "R9 load held", {19'b0, ld_index, ld_code}, {19'b0, 3'(i), c0});
        end
        chk(ld_index == 3'(i), "R8 index order", {29'b0, ld_index}, i);
        chk(ld_code == model_code(s, i), "R8 code value", {22'b0, ld_code}, {22'b0, model_code(s, i)});
        ld_ready = 1'b1;
        @(negedge clk);
        ld_ready = 1'b0;
      end
      chk(!ld_valid && rd_byte_ready, "R8 loads end", {30'b0, ld_valid, rd_byte_ready}, 32'd1);
    end
  endtask

  task automatic t_reset;
    chk(wr_word_ready && rd_byte_ready, "R1 ready after reset", {30'b0, wr_word_ready, rd_byte_ready}, 32'd3);
    chk(!wr_byte_valid && !wr_byte_last && !ld_valid, "R1 no output after reset", {29'b0, wr_byte_valid, wr_byte_last, ld_valid}, 32'd0);
    chk(!rd_done && !rd_erased, "R1 no done after reset", {30'b0, rd_done, rd_erased}, 32'd0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [127:0] wa, wb, wf;
    logic [79:0]  ga, gb, gf, s;
    wa = {mk_word(10'h2C3, 10'h05A, 6'h00), mk_word(10'h3FF, 10'h001, 6'h00),
          mk_word(10'h155, 10'h2AA, 6'h00), mk_word(10'h123, 10'h3E7, 6'h00)};
    wb = {mk_word(10'h2C3, 10'h05A, 6'h3F), mk_word(10'h3FF, 10'h001, 6'h2A),
          mk_word(10'h155, 10'h2AA, 6'h15), mk_word(10'h123, 10'h3E7, 6'h3F)};
    wf = {4{mk_word(10'h3FF, 10'h3FF, 6'h00)}};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pack(wa, 1'b1, "R3 packed byte", ga);
    t_pack(wb, 1'b0, "R2 junk bits ignored", gb);
    chk(ga == gb, "R2 same stream with junk", ga[31:0], gb[31:0]);
    t_pack(wf, 1'b0, "R3 all-ones codes", gf);
    t_unpack(ga, 1'b0, 1'b1, "R6 normal frame not erased");
    s = {80{1'b1}};
    t_unpack(s, 1'b1, 1'b0, "R7 erased flag");
    s[79:72] = 8'hFE;
    t_unpack(s, 1'b0, 1'b0, "R10 one byte off not erased");
    s = {80{1'b1}};
    t_unpack(s, 1'b1, 1'b0, "R10 tracker rearmed");
    s = {80{1'b1}}; s[7:0] = 8'h7F;
    t_unpack(s, 1'b0, 1'b0, "R10 first byte off not erased");
    t_unpack(80'h0123_4567_89AB_CDEF_0F1E, 1'b0, 1'b1, "R6 mixed frame not erased");
    summary();
  end
endmodule